// File: doc/BRIEF.md
# Programmable Display Sync Generator

This block produces the raster timing for one display pipe. A horizontal pixel counter and a vertical line counter run on the pixel clock. Their limits come from software-written timing words, and from them the block derives horizontal sync, vertical sync and a data-enable strobe. Each sync has its own window, its own enable bit and its own polarity-invert bit. A separate output-control word gates and inverts data-enable and drives the enable and polarity of the outgoing pixel clock.

Software writes new timing words at any time. They are held in a pending copy and move into the working copy only at the start of a frame, so a frame is never built from a mix of old and new values. The block also shows the live scan position as one 32-bit word. It emits a one-cycle pulse at the first blanking line and keeps a free-running count of those pulses.

Top module: `disp_sync_gen`

## Requirements
- R1: The X counter steps once per pixel clock over 0 to H_total-1 and then returns to 0. The Y counter steps once when X returns to 0, over 0 to V_total-1. A total of 0 or 1 holds that counter at 0.
- R2: Horizontal sync word: bit 31 inverts, bit 30 enables, bits [28:16] give the end and bits [12:0] give the start. hsync equals invert XOR (enable AND start <= X < end). When enable is 0, hsync stays at the invert value.
- R3: Vertical sync word: bit 31 inverts, bit 30 enables, bits [27:16] give the end and bits [11:0] give the start. vsync follows the same rule as R2, applied to Y.
- R4: Display words hold the active size in bits [15:0] and the total in bits [31:16], using as many bits as the counter width. The area is active when X < H_active and Y < V_active. de equals de_invert (output-control bit 1) XOR (data_enable (bit 0) AND active).
- R5: clk_out_en follows output-control bit 8 and clk_out_inv follows bit 9, from the clock after the write. The output-control word takes effect without waiting for a frame start.
- R6: A write to any of the four timing words changes nothing until the frame-start edge, where X and Y both return to 0. From there the value last written before that edge applies.
- R7: vblank is high for exactly one clock at X = 0, Y = V_active, and only when V_active < V_total. vblank_count rises by one after each pulse and wraps modulo 2^CNT_W.
- R8: scan_pos holds X in bits [31:16] and Y in bits [15:0], zero-extended.
- R9: After reset all words and counters are 0, so hsync, vsync, de and vblank are 0, and scan_pos and vblank_count stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rst_n | input | 1 | asynchronous active-low reset |
| hdisp_we | input | 1 | write wdata to horizontal display word |
| hsync_we | input | 1 | write wdata to horizontal sync word |
| vdisp_we | input | 1 | write wdata to vertical display word |
| vsync_we | input | 1 | write wdata to vertical sync word |
| outctl_we | input | 1 | write wdata to output-control word |
| wdata | input | 32 | write data shared by all words |
| hsync | output | 1 | horizontal sync |
| vsync | output | 1 | vertical sync |
| de | output | 1 | data enable |
| vblank | output | 1 | one-clock pulse at first blanking line |
| clk_out_en | output | 1 | pixel clock output enable |
| clk_out_inv | output | 1 | pixel clock output polarity |
| scan_pos | output | 32 | live X (high half) and Y (low half) |
| vblank_count | output | CNT_W | number of vblank pulses |

## Verification
Two events can meet in one clock: a timing-word write and the frame-start edge, and a vblank pulse and the wrap of the line counter when V_active is one less than V_total. The bench fires random writes at random points in the frame, so some of them land exactly on frame start and must commit the value held before that edge. A reference model then judges every output on every cycle. Short random frames force vblank onto the last line, and the count must still step exactly once per pulse.

// File: rtl/disp_sync_pkg.sv
package disp_sync_pkg;
  localparam int REG_W    = 32;
  localparam int FLD_HI   = 16;
  localparam int N_TIMING = 4;
  // timing word slots
  localparam int SLOT_HDISP = 0;
  localparam int SLOT_HSYNC = 1;
  localparam int SLOT_VDISP = 2;
  localparam int SLOT_VSYNC = 3;
  // sync word control bits
  localparam int B_SYNC_INV = 31;
  localparam int B_SYNC_EN  = 30;
  // output-control bits
  localparam int B_DATA_EN  = 0;
  localparam int B_DE_INV   = 1;
  localparam int B_CK_EN    = 8;
  localparam int B_CK_INV   = 9;
endpackage

// File: rtl/disp_axis_cnt.sv
module disp_axis_cnt #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] total,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] cnt_q, cnt_d;
  logic [W:0]   nxt;
  logic         at_end;

  always_comb begin
    nxt    = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
    at_end = nxt >= {1'b0, total};
    wrap   = adv & at_end;
    cnt_d  = at_end ? '0 : nxt[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (adv) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R1: the counter never leaves its range
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (total != '0) |-> (cnt_q < total));
  // R1: the counter only steps by one or returns to zero
  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == '0)));
endmodule

// File: rtl/disp_timing_regs.sv
module disp_timing_regs
  import disp_sync_pkg::*;
#(
  parameter int N  = N_TIMING,
  parameter int DW = REG_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         we,
  input  logic [DW-1:0]        wdata,
  input  logic                 commit,
  output logic [N-1:0][DW-1:0] act
);
  logic [N-1:0][DW-1:0] pend_q, pend_d, act_q, act_d;

  for (genvar i = 0; i < N; i++) begin : g_slot
    always_comb begin
      pend_d[i] = we[i] ? wdata : pend_q[i];
      act_d[i]  = pend_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pend_q[i] <= '0;
      else if (we[i]) pend_q[i] <= pend_d[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      act_q[i] <= '0;
      else if (commit) act_q[i] <= act_d[i];
    end
  end

  assign act = act_q;

  // R6: working timing only changes on a frame-start edge
  p_commit_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> $past(commit));
endmodule

// File: rtl/disp_sync_shape.sv
module disp_sync_shape #(
  parameter int W = 13
) (
  input  logic [W-1:0] pos,
  input  logic [W-1:0] start,
  input  logic [W-1:0] stop,
  input  logic         en,
  input  logic         inv,
  output logic         level
);
  logic in_win;

  always_comb begin
    in_win = (pos >= start) && (pos < stop);
    level  = inv ^ (en & in_win);
  end
endmodule

// File: rtl/disp_vblank_cnt.sv
module disp_vblank_cnt #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pulse,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb cnt_d = cnt_q + {{(CW-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (pulse) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R7: each pulse adds exactly one
  p_vb_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R7: no pulse, no change
  p_vb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse |=> $stable(cnt_q));
endmodule

// File: rtl/disp_sync_gen.sv
module disp_sync_gen
  import disp_sync_pkg::*;
#(
  parameter int HW    = 13,
  parameter int VW    = 12,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hdisp_we,
  input  logic             hsync_we,
  input  logic             vdisp_we,
  input  logic             vsync_we,
  input  logic             outctl_we,
  input  logic [31:0]      wdata,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic             vblank,
  output logic             clk_out_en,
  output logic             clk_out_inv,
  output logic [31:0]      scan_pos,
  output logic [CNT_W-1:0] vblank_count
);
  localparam int POS_W = REG_W / 2;

  logic [N_TIMING-1:0]            tw_we;
  logic [N_TIMING-1:0][REG_W-1:0] act;
  logic [HW-1:0] x, h_act, h_tot, hs_start, hs_stop;
  logic [VW-1:0] y, v_act, v_tot, vs_start, vs_stop;
  logic          h_wrap, v_wrap, area;
  logic [3:0]    oc_q, oc_d;
  logic          unused_bits;

  assign tw_we = {vsync_we, vdisp_we, hsync_we, hdisp_we};

  disp_timing_regs #(.N(N_TIMING), .DW(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(tw_we), .wdata(wdata),
    .commit(v_wrap), .act(act));

  always_comb begin
    h_act    = act[SLOT_HDISP][HW-1:0];
    h_tot    = act[SLOT_HDISP][FLD_HI+HW-1:FLD_HI];
    hs_start = act[SLOT_HSYNC][HW-1:0];
    hs_stop  = act[SLOT_HSYNC][FLD_HI+HW-1:FLD_HI];
    v_act    = act[SLOT_VDISP][VW-1:0];
    v_tot    = act[SLOT_VDISP][FLD_HI+VW-1:FLD_HI];
    vs_start = act[SLOT_VSYNC][VW-1:0];
    vs_stop  = act[SLOT_VSYNC][FLD_HI+VW-1:FLD_HI];
  end

  assign unused_bits = ^act;

  disp_axis_cnt #(.W(HW)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .adv(1'b1), .total(h_tot), .cnt(x), .wrap(h_wrap));

  disp_axis_cnt #(.W(VW)) u_vcnt (
    .clk(clk), .rst_n(rst_n), .adv(h_wrap), .total(v_tot), .cnt(y), .wrap(v_wrap));

  disp_sync_shape #(.W(HW)) u_hs (
    .pos(x), .start(hs_start), .stop(hs_stop),
    .en(act[SLOT_HSYNC][B_SYNC_EN]), .inv(act[SLOT_HSYNC][B_SYNC_INV]), .level(hsync));

  disp_sync_shape #(.W(VW)) u_vs (
    .pos(y), .start(vs_start), .stop(vs_stop),
    .en(act[SLOT_VSYNC][B_SYNC_EN]), .inv(act[SLOT_VSYNC][B_SYNC_INV]), .level(vsync));

  // output control: {ck_inv, ck_en, de_inv, data_en}
  always_comb oc_d = {wdata[B_CK_INV], wdata[B_CK_EN], wdata[B_DE_INV], wdata[B_DATA_EN]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         oc_q <= '0;
    else if (outctl_we) oc_q <= oc_d;
  end

  always_comb begin
    area        = (x < h_act) && (y < v_act);
    de          = oc_q[1] ^ (oc_q[0] & area);
    clk_out_en  = oc_q[2];
    clk_out_inv = oc_q[3];
    vblank      = (x == '0) && (y == v_act) && (v_act < v_tot);
    scan_pos    = {{(POS_W-HW){1'b0}}, x, {(POS_W-VW){1'b0}}, y};
  end

  disp_vblank_cnt #(.CW(CNT_W)) u_vbc (
    .clk(clk), .rst_n(rst_n), .pulse(vblank), .cnt(vblank_count));

  // R7: the pulse lasts a single clock unless a line is one pixel long
  p_vb_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank && h_tot > 1) |=> !vblank);
  // R4: data enable off while the output-control word gates it off
  p_de_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !oc_q[0] |-> (de == oc_q[1]));
endmodule

// File: tb/disp_sync_gen_bench.sv
module disp_sync_gen_bench;
  logic        clk, rst_n;
  logic        hdisp_we, hsync_we, vdisp_we, vsync_we, outctl_we;
  logic [31:0] wdata;
  logic        hsync, vsync, de, vblank, clk_out_en, clk_out_inv;
  logic [31:0] scan_pos, vblank_count;

  int errors = 0, checks = 0, cyc = 0;
  bit chk_on = 0;

  disp_sync_gen u_disp_sync_gen (
    .clk(clk), .rst_n(rst_n), .hdisp_we(hdisp_we), .hsync_we(hsync_we),
    .vdisp_we(vdisp_we), .vsync_we(vsync_we), .outctl_we(outctl_we), .wdata(wdata),
    .hsync(hsync), .vsync(vsync), .de(de), .vblank(vblank),
    .clk_out_en(clk_out_en), .clk_out_inv(clk_out_inv),
    .scan_pos(scan_pos), .vblank_count(vblank_count));

  initial clk = 0;
  always #5 clk = ~clk;

  // reference model
  logic [31:0] p_hd, p_hs, p_vd, p_vs, a_hd, a_hs, a_vd, a_vs, m_cnt;
  logic [3:0]  m_oc;
  int mx, my;

  function automatic int htot(logic [31:0] w); return int'((w >> 16) & 32'h1fff); endfunction
  function automatic int hact(logic [31:0] w); return int'(w & 32'h1fff); endfunction
  function automatic int vtot(logic [31:0] w); return int'((w >> 16) & 32'hfff); endfunction
  function automatic int vact(logic [31:0] w); return int'(w & 32'hfff); endfunction
  function automatic logic exp_sync(int p, int s, int e, logic en, logic inv);
    return inv ^ (en && p >= s && p < e);
  endfunction
  function automatic logic [31:0] mk_disp(int a, int t);
    return (32'(t) << 16) | 32'(a);
  endfunction
  function automatic logic [31:0] mk_sync(bit inv, bit en, int e, int s);
    return (32'(inv) << 31) | (32'(en) << 30) | (32'(e) << 16) | 32'(s);
  endfunction
  function automatic logic exp_vb(int x, int y);
    return x == 0 && y == vact(a_vd) && vact(a_vd) < vtot(a_vd);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_hd <= 0; p_hs <= 0; p_vd <= 0; p_vs <= 0;
      a_hd <= 0; a_hs <= 0; a_vd <= 0; a_vs <= 0;
      m_cnt <= 0; m_oc <= 0; mx <= 0; my <= 0;
    end else begin
      automatic bit hw = (mx + 1) >= htot(a_hd);
      automatic bit vw = hw && ((my + 1) >= vtot(a_vd));
      if (hdisp_we) p_hd <= wdata;
      if (hsync_we) p_hs <= wdata;
      if (vdisp_we) p_vd <= wdata;
      if (vsync_we) p_vs <= wdata;
      if (outctl_we) m_oc <= {wdata[9], wdata[8], wdata[1], wdata[0]};
      if (exp_vb(mx, my)) m_cnt <= m_cnt + 1;
      mx <= hw ? 0 : mx + 1;
      if (hw) my <= vw ? 0 : my + 1;
      if (vw) begin a_hd <= p_hd; a_hs <= p_hs; a_vd <= p_vd; a_vs <= p_vs; end
    end
  end

  task automatic check(string tag, logic [31:0] act_v, logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act_v, exp_v, cyc);
    end
  endtask

  always @(negedge clk) if (chk_on) begin
    check("R1/R8 scan_pos", scan_pos, {16'(mx), 16'(my)});
    check("R2 hsync", 32'(hsync), 32'(exp_sync(mx, int'(a_hs & 32'h1fff),
          int'((a_hs >> 16) & 32'h1fff), a_hs[30], a_hs[31])));
    check("R3 vsync", 32'(vsync), 32'(exp_sync(my, int'(a_vs & 32'hfff),
          int'((a_vs >> 16) & 32'hfff), a_vs[30], a_vs[31])));
    check("R4 de", 32'(de), 32'(m_oc[1] ^ (m_oc[0] && mx < hact(a_hd) && my < vact(a_vd))));
    check("R5 clk_out_en", 32'(clk_out_en), 32'(m_oc[2]));
    check("R5 clk_out_inv", 32'(clk_out_inv), 32'(m_oc[3]));
    check("R7 vblank", 32'(vblank), 32'(exp_vb(mx, my)));
    check("R7 vblank_count", vblank_count, m_cnt);
  end

  task automatic wr(int sel, logic [31:0] d);
    @(negedge clk);
    wdata = d;
    hdisp_we = sel == 0; hsync_we = sel == 1; vdisp_we = sel == 2;
    vsync_we = sel == 3; outctl_we = sel == 4;
    @(negedge clk);
    hdisp_we = 0; hsync_we = 0; vdisp_we = 0; vsync_we = 0; outctl_we = 0;
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, 150000);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 0; hdisp_we = 0; hsync_we = 0; vdisp_we = 0; vsync_we = 0;
    outctl_we = 0; wdata = 0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 hsync", 32'(hsync), 0);
    check("R9 vsync", 32'(vsync), 0);
    check("R9 de", 32'(de), 0);
    check("R9 vblank", 32'(vblank), 0);
    check("R9 scan_pos", scan_pos, 0);
    check("R9 vblank_count", vblank_count, 0);
    rst_n = 1;
    chk_on = 1;
    repeat (8) @(negedge clk);
    check("R9 idle count", vblank_count, 0);

    // directed timing
    wr(0, mk_disp(12, 20));
    wr(1, mk_sync(0, 1, 17, 14));
    wr(2, mk_disp(6, 10));
    wr(3, mk_sync(1, 1, 9, 7));
    wr(4, 32'h301);
    repeat (500) @(negedge clk);

    // R6: mid-frame shrink of the line total must not act before frame start
    while (!(scan_pos[31:16] == 5 && scan_pos[15:0] == 2)) @(negedge clk);
    wdata = mk_disp(4, 8); hdisp_we = 1;
    @(negedge clk); hdisp_we = 0;
    repeat (9) @(negedge clk);
    check("R6 old total kept", 32'(scan_pos[31:16]), 15);
    repeat (600) @(negedge clk);

    // corners: empty window, disabled inverted sync, gated inverted de
    wr(1, mk_sync(0, 1, 3, 3));
    wr(3, mk_sync(1, 0, 5, 1));
    wr(4, 32'h002);
    repeat (300) @(negedge clk);
    check("R2 empty window", 32'(hsync), 0);
    check("R3 disabled inverted", 32'(vsync), 1);
    check("R4 gated inverted de", 32'(de), 1);

    // random configurations, writes at random points of the frame
    for (int n = 0; n < 60; n++) begin
      automatic int ht = 1 + int'($urandom_range(0, 23));
      automatic int vt = 1 + int'($urandom_range(0, 11));
      for (int k = 0; k < 5; k++) begin
        automatic logic [31:0] d;
        case (k)
          0: d = mk_disp(int'($urandom_range(0, ht)), ht);
          1: d = mk_sync(1'($urandom), 1'($urandom), int'($urandom_range(0, ht)),
                         int'($urandom_range(0, ht)));
          2: d = mk_disp(int'($urandom_range(0, vt)), vt);
          3: d = mk_sync(1'($urandom), 1'($urandom), int'($urandom_range(0, vt)),
                         int'($urandom_range(0, vt)));
          default: d = $urandom & 32'h303;
        endcase
        wr(k, d);
        repeat (int'($urandom_range(0, 40))) @(negedge clk);
      end
      repeat (int'($urandom_range(100, 500))) @(negedge clk);
    end

    chk_on = 0;
    finish_run();
  end
endmodule